// File: doc/BRIEF.md
# Sample Insert/Drop Timing Compensator

This block sits in the receive sample path of a 2.4 GHz O-QPSK demodulator for IEEE 802.15.4. It corrects the slow drift between transmitter and receiver sampling clocks without touching the ADC clock. Instead, it removes or duplicates one whole complex sample at points spaced evenly through the packet. Each such edit shifts all later samples by one sample period relative to the despreader's reference chip patterns.

A signed frequency-offset code is presented together with a one-cycle packet-sync pulse. The code is the estimate formed over the preamble, in steps of 4 ppm. At that pulse the block captures the code, clears its sample counter and looks up two spacings in a 16-entry table. The first spacing is where the accumulated drift first reaches half a sample. The second is the distance between later edits. The table is computed at elaboration from parameters, for an 8 MHz sample rate and packets of up to about 34,000 samples. Drift smaller than one sample between edits is left alone. A packet-end pulse freezes the correction until the next sync.

Top module: `sample_slip_comp`

## Requirements
- R1: While reset is low, and in the cycle after reset, `dout_valid` is 0. After reset and before the first `sync_i` pulse, no sample is dropped or inserted.
- R2: When no correction applies, each valid input sample appears on `dout_i`/`dout_q` with `dout_valid` high exactly one clock later, with unchanged I and Q.
- R3: `offset_code` is a 5-bit two's-complement value sampled in the cycle `sync_i` is high. Its magnitude k (1..15) selects 4k ppm. The code -16 is treated as magnitude 15. A positive code means the receiver clock is fast; a negative code means it is slow.
- R4: Samples are indexed from 0, starting with the first valid sample in or after the sync cycle. The first correction acts on index F = floor(125000/k).
- R5: Later corrections act on indices F + n·L, with L = floor(250000/k) and n = 1, 2, …
- R6: An interval larger than 34000, or one that does not fit in 16 bits, means no correction at that stage. This makes k = 1..3 correction-free and gives k = 4..7 a single correction at F.
- R7: For a positive code, the corrected sample is dropped: no `dout_valid` strobe is produced for it.
- R8: For a negative code, on the corrected sample the previous output sample is strobed again. The corrected sample itself follows on the next clock.
- R9: Code 0 makes no correction. A `pkt_end_i` pulse disables correction, including for a sample arriving in the same cycle, until the next `sync_i`.
- R10: Input valid strobes are at least one idle cycle apart. The one-sample insert buffer never holds data when a new sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Packet-sync pulse; captures the code and clears the count |
| pkt_end_i | input | 1 | Packet-end pulse; stops corrections |
| offset_code | input | 5 | Signed offset estimate, 4 ppm per step |
| din_i | input | 12 | In-phase input sample |
| din_q | input | 12 | Quadrature input sample |
| din_valid | input | 1 | Input sample strobe |
| dout_i | output | 12 | In-phase output sample |
| dout_q | output | 12 | Quadrature output sample |
| dout_valid | output | 1 | Output sample strobe |

## Verification
Assertions check the output stage on every cycle. They cover the one-cycle pass-through of uncorrected samples, the missing strobe after a drop, and the two-beat repeat-then-current pattern of an insert. They also check that the single insert buffer is never overrun. Where the edits fall (F and F + n·L for each code), the empty entries of the table, code 0, and freezing at packet end can only be shown by the bench scenarios. These feed an index ramp and compare the whole output stream against a model built from the requirements.

// File: rtl/slip_pkg.sv
// Shared helpers for the sample insert/drop compensator.
// Assumes intervals are expressed in input samples.
package slip_pkg;

    // Interval in samples for table entry k: num/k, or all-ones when unusable.
    function automatic int slip_interval(int k, int num, int max_len, int intv_w);
        int ones;
        int v;
        ones = (1 << intv_w) - 1;
        if (k == 0) return ones;
        v = num / k;
        if (v > max_len || v >= ones) return ones;
        return v;
    endfunction

endpackage

// File: rtl/slip_lut.sv
// Offset-magnitude to interval table, computed at elaboration.
// Assumes entry 0 means zero offset (no correction).
module slip_lut #(
    parameter int N_ENT    = 16,
    parameter int INTV_W   = 16,
    parameter int HALF_NUM = 125000,
    parameter int MAX_LEN  = 34000,
    localparam int IDX_W   = $clog2(N_ENT)
) (
    input  logic [IDX_W-1:0]  mag,
    output logic [INTV_W-1:0] first_o,
    output logic [INTV_W-1:0] later_o
);
    import slip_pkg::*;

    logic [INTV_W-1:0] tab_first [N_ENT];
    logic [INTV_W-1:0] tab_later [N_ENT];

    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        localparam int FV = slip_interval(k, HALF_NUM, MAX_LEN, INTV_W);
        localparam int LV = slip_interval(k, 2 * HALF_NUM, MAX_LEN, INTV_W);
        assign tab_first[k] = INTV_W'(FV);
        assign tab_later[k] = INTV_W'(LV);
    end

    // Read both intervals for the selected magnitude.
    always_comb begin
        first_o = tab_first[mag];
        later_o = tab_later[mag];
    end
endmodule

// File: rtl/slip_timer.sv
// Counts valid samples since packet sync and flags the correction points.
// Assumes sync_i is a single-cycle pulse.
module slip_timer #(
    parameter int N_ENT    = 16,
    parameter int INTV_W   = 16,
    parameter int HALF_NUM = 125000,
    parameter int MAX_LEN  = 34000,
    localparam int IDX_W   = $clog2(N_ENT),
    localparam int CODE_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              pkt_end_i,
    input  logic [CODE_W-1:0] offset_code,
    input  logic              din_valid,
    output logic              hit_o,
    output logic              drop_o
);
    localparam logic [INTV_W-1:0] ONES = '1;

    logic [IDX_W-1:0]  mag_q, mag_n, mag_e;
    logic              drop_q, drop_e;
    logic              act_q, act_e;
    logic [INTV_W-1:0] rem_q, rem_e;
    logic [INTV_W-1:0] first_w, later_w;
    logic [CODE_W-1:0] neg_code;

    slip_lut #(.N_ENT(N_ENT), .INTV_W(INTV_W), .HALF_NUM(HALF_NUM), .MAX_LEN(MAX_LEN))
        u_lut (.mag(mag_e), .first_o(first_w), .later_o(later_w));

    // Convert the signed code to a saturated magnitude.
    always_comb begin
        neg_code = -offset_code;
        if (!offset_code[CODE_W-1])
            mag_n = offset_code[IDX_W-1:0];
        else if (offset_code == {1'b1, {IDX_W{1'b0}}})
            mag_n = '1;
        else
            mag_n = neg_code[IDX_W-1:0];
    end

    // Effective state for this cycle, letting a sync pulse take effect at once.
    always_comb begin
        mag_e  = sync_i ? mag_n : mag_q;
        drop_e = sync_i ? !offset_code[CODE_W-1] : drop_q;
        act_e  = sync_i ? (first_w != ONES) : act_q;
        rem_e  = sync_i ? first_w : rem_q;
        hit_o  = act_e && din_valid && !pkt_end_i && (rem_e == '0);
        drop_o = drop_e;
    end

    // Capture the offset and step the down-counter on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q  <= '0;
            drop_q <= 1'b0;
            act_q  <= 1'b0;
            rem_q  <= '0;
        end else begin
            mag_q  <= mag_e;
            drop_q <= drop_e;
            if (pkt_end_i) begin
                act_q <= 1'b0;
                rem_q <= rem_e;
            end else if (din_valid && act_e) begin
                if (rem_e == '0) begin
                    act_q <= (later_w != ONES);
                    rem_q <= later_w - 1'b1;
                end else begin
                    act_q <= 1'b1;
                    rem_q <= rem_e - 1'b1;
                end
            end else begin
                act_q <= act_e;
                rem_q <= rem_e;
            end
        end
    end
endmodule

// File: rtl/slip_emitter.sv
// Output register stage that passes, drops or duplicates one sample.
// Assumes input valid strobes never arrive on consecutive cycles.
module slip_emitter #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          din_valid,
    input  logic          hit,
    input  logic          drop,
    output logic [DW-1:0] dout,
    output logic          dout_valid
);
    logic [DW-1:0] pend_q;
    logic          pend_valid;

    // Emit held data first, otherwise pass, drop or repeat the new sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
            pend_q     <= '0;
            pend_valid <= 1'b0;
        end else if (pend_valid) begin
            dout       <= pend_q;
            dout_valid <= 1'b1;
            pend_valid <= 1'b0;
        end else if (din_valid) begin
            if (hit && drop) begin
                dout_valid <= 1'b0;
            end else if (hit) begin
                dout_valid <= 1'b1;
                pend_q     <= din;
                pend_valid <= 1'b1;
            end else begin
                dout       <= din;
                dout_valid <= 1'b1;
            end
        end else begin
            dout_valid <= 1'b0;
        end
    end

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && !hit && !pend_valid) |=> (dout_valid && dout == $past(din)));

    a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && hit && drop && !pend_valid) |=> !dout_valid);

    a_r8_insert_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && hit && !drop && !pend_valid) |=>
            (dout_valid && $stable(dout)) ##1 (dout_valid && dout == $past(din, 2)));

    a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> !din_valid);
endmodule

// File: rtl/sample_slip_comp.sv
// Sample insert/drop timing compensator: corrects sampling-clock drift by
// removing or duplicating whole samples at table-driven points after sync.
// Assumes one offset estimate per packet and spaced input valid strobes.
module sample_slip_comp #(
    parameter int SW       = 12,
    parameter int N_ENT    = 16,
    parameter int INTV_W   = 16,
    parameter int HALF_NUM = 125000,
    parameter int MAX_LEN  = 34000,
    localparam int CODE_W  = $clog2(N_ENT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              pkt_end_i,
    input  logic [CODE_W-1:0] offset_code,
    input  logic [SW-1:0]     din_i,
    input  logic [SW-1:0]     din_q,
    input  logic              din_valid,
    output logic [SW-1:0]     dout_i,
    output logic [SW-1:0]     dout_q,
    output logic              dout_valid
);
    logic          hit_w, drop_w;
    logic [2*SW-1:0] out_w;

    slip_timer #(.N_ENT(N_ENT), .INTV_W(INTV_W), .HALF_NUM(HALF_NUM), .MAX_LEN(MAX_LEN))
        u_timer (
            .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .pkt_end_i(pkt_end_i),
            .offset_code(offset_code), .din_valid(din_valid),
            .hit_o(hit_w), .drop_o(drop_w)
        );

    slip_emitter #(.DW(2 * SW))
        u_emit (
            .clk(clk), .rst_n(rst_n), .din({din_i, din_q}), .din_valid(din_valid),
            .hit(hit_w), .drop(drop_w), .dout(out_w), .dout_valid(dout_valid)
        );

    assign dout_i = out_w[2*SW-1:SW];
    assign dout_q = out_w[SW-1:0];
endmodule

// File: tb/sample_slip_comp_bench.sv
module sample_slip_comp_bench;
    localparam int SW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0;
    logic pkt_end_i = 1'b0;
    logic [4:0] offset_code = '0;
    logic [SW-1:0] din_i = '0;
    logic [SW-1:0] din_q = '0;
    logic din_valid = 1'b0;
    logic [SW-1:0] dout_i, dout_q;
    logic dout_valid;

    int checks = 0;
    int errors = 0;
    int out_count = 0;
    string cur_req = "R1";
    logic [SW-1:0] expq[$];

    always #10 clk = ~clk;

    sample_slip_comp u_sample_slip_comp (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .pkt_end_i(pkt_end_i),
        .offset_code(offset_code), .din_i(din_i), .din_q(din_q), .din_valid(din_valid),
        .dout_i(dout_i), .dout_q(dout_q), .dout_valid(dout_valid)
    );

    task automatic check(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare each output beat with the model queue.
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            out_count++;
            if (expq.size() == 0) begin
                check(cur_req, 1'b0, int'(dout_i), -1);
            end else begin
                logic [SW-1:0] e;
                e = expq.pop_front();
                check(cur_req, dout_i == e && dout_q == ~e, int'(dout_i), int'(e));
            end
        end
    end

    // Interval from the requirements: -1 means no correction.
    function automatic int intv(int k, int num);
        int v;
        if (k == 0) return -1;
        v = num / k;
        if (v > 34000 || v >= 65535) return -1;
        return v;
    endfunction

    // Feed a ramp of n samples; build the expected output stream.
    task automatic run_stream(string req, int n, int code, bit do_sync, int end_idx,
                              int exp_outs);
        int k, f, l, outs0;
        bit ended;
        k = (code < 0) ? ((code == -16) ? 15 : -code) : code;
        f = intv(k, 125000);
        l = intv(k, 250000);
        ended = 0;
        cur_req = req;
        outs0 = out_count;
        if (do_sync) begin
            @(posedge clk); #1;
            sync_i = 1'b1; offset_code = 5'(code);
            @(posedge clk); #1;
            sync_i = 1'b0;
        end
        for (int j = 0; j < n; j++) begin
            bit corr;
            logic [SW-1:0] v;
            v = SW'(j);
            if (j == end_idx) ended = 1;
            corr = do_sync && !ended && f >= 0 &&
                   (j == f || (l > 0 && j > f && (j - f) % l == 0));
            if (!corr) expq.push_back(v);
            else if (code < 0) begin
                expq.push_back(SW'(j - 1));
                expq.push_back(v);
            end
            din_valid = 1'b1; din_i = v; din_q = ~v;
            pkt_end_i = (j == end_idx);
            @(posedge clk); #1;
            din_valid = 1'b0; pkt_end_i = 1'b0;
            @(posedge clk); #1;
        end
        repeat (4) @(posedge clk);
        #1;
        check(req, expq.size() == 0, expq.size(), 0);
        check(req, out_count - outs0 == exp_outs, out_count - outs0, exp_outs);
        expq.delete();
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1", dout_valid == 1'b0, int'(dout_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", dout_valid == 1'b0, int'(dout_valid), 0);
    endtask

    // R1/R2: no sync yet, plain one-cycle pass-through.
    task automatic t_no_sync;
        run_stream("R1", 200, 15, 1'b0, -1, 200);
    endtask

    // R4, R5, R8: code -15, inserts at 8333 and 24999.
    task automatic t_neg15;
        run_stream("R8", 25100, -15, 1'b1, -1, 25102);
    endtask

    // R4, R7: code +15, drop at 8333.
    task automatic t_pos15;
        run_stream("R7", 9000, 15, 1'b1, -1, 8999);
    endtask

    // R3/R4: code -16 behaves as magnitude 15, insert at 8333.
    task automatic t_neg16;
        run_stream("R3", 8500, -16, 1'b1, -1, 8501);
    endtask

    // R4: code +9, drop at 13888.
    task automatic t_pos9;
        run_stream("R4", 14000, 9, 1'b1, -1, 13999);
    endtask

    // R6: code 3 has no usable interval.
    task automatic t_small;
        run_stream("R6", 3000, 3, 1'b1, -1, 3000);
    endtask

    // R9: code 0 and packet end before the first point.
    task automatic t_end;
        run_stream("R9", 500, 0, 1'b1, -1, 500);
        run_stream("R9", 9000, -15, 1'b1, 4000, 9000);
    endtask

    initial begin
        t_reset();
        t_no_sync();
        t_pos15();
        t_neg15();
        t_pos9();
        t_small();
        t_end();
        t_neg16();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule